// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block sits between a host register bus and a multiplexed analog-to-digital converter front end. The host writes a 16-bit control word that picks the channel to convert, drives a per-channel enable mask out to the front end, and can request a settling delay. The same word carries a start bit. When a start is accepted, the block optionally waits out the settling time. It then sends a one-cycle start strobe to the converter and follows the converter's busy line until the result is ready.

On completion the result is converted to two's complement and stored in a data register. A done flag is raised in a status register, and the host clears that flag by writing a one to it. An interrupt-enable register gates the done flag onto the interrupt output. There are ten channels: eight differential inputs (0 to 7), a positive full-scale reference (8) and a zero reference (9).

Register map (2-bit address): 0 = control, 1 = status, 2 = interrupt enable, 3 = result data (read-only). A read returns the addressed register one clock after the address is presented.

Top module: `adc_mux_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` and `cnv_start` are low.
- R2: A control write with bit 0 set, while the block is idle, produces exactly one `cnv_start` pulse, in the cycle right after the write when bit 15 is clear. `cnv_chan` shows control bits 4:1, and `ch_enable` shows control bits 14:5 (bit 5 is channel 0).
- R3: When control bit 15 is set, the `cnv_start` pulse comes DELAY_CYC cycles later than it would with bit 15 clear.
- R4: When the converter drops `cnv_busy`, the result is stored with bit 15 inverted, which turns the converter's offset-binary code into two's complement. The stored value reads back at address 3.
- R5: Completion sets status bit 2 (done). Status bit 0 reads 1 from the accepted start until the done edge.
- R6: Writing status with bit 2 set clears done, and writing it with bit 2 clear leaves done unchanged. If a completion and a clear land in the same cycle, done is set.
- R7: Interrupt-enable bit 2 gates done onto `irq`. The other bits of that register read zero.
- R8: A control write while a conversion is in progress is ignored: the control readback does not change, no second strobe is sent, and done is set only by the running conversion.
- R9: A start whose selected channel is 10 or above, or whose enable-mask bit is clear, sends no strobe and leaves the data register unchanged. It sets done immediately.
- R10: Control readback bit 0 always reads 0, writes to address 3 are ignored, and read data is registered with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| irq | output | 1 | Conversion-done interrupt |
| cnv_start | output | 1 | One-cycle converter start strobe |
| cnv_chan | output | 4 | Multiplexer channel select |
| ch_enable | output | 10 | Per-channel front-end enables |
| cnv_busy | input | 1 | Converter busy |
| cnv_result | input | 16 | Converter result, offset binary, valid when busy falls |

## Verification
Starts are issued on a differential channel and then on another channel with the settling delay set. Comparing the two strobe timings separates the delayed path from the direct one. A second control word written during a running conversion, plus starts on an out-of-range channel and on a masked-off channel, show whether a start is correctly refused or cancelled without disturbing the data register. Status writes with bit 2 clear and set, and a conversion with interrupts disabled, separate the clear behaviour of the done flag from the gating of the interrupt. A behavioural model in the bench predicts every output each cycle.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SETTLE = 3'd1,
    S_LAUNCH = 3'd2,
    S_WAITHI = 3'd3,
    S_WAITLO = 3'd4
  } seq_state_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_IEN  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int BUSY_BIT = 0;
  localparam int DONE_BIT = 2;
endpackage

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctl_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CHW       = 4,
  parameter int NCH       = 10,
  parameter int DELAY_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [DW-1:0] ctrl_wdata,
  input  logic          busy_i,
  input  logic [DW-1:0] result_i,
  output logic          busy_o,
  output logic [DW-1:0] ctrl_o,
  output logic          cnv_start_o,
  output logic          done_evt_o,
  output logic          res_we_o,
  output logic [DW-1:0] res_o
);
  localparam int MASK_LSB = CHW + 1;
  localparam int DLY_BIT  = DW - 1;
  localparam int NSEL     = 2 ** CHW;
  localparam int CW       = $clog2(DELAY_CYC + 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] ctrl_q;

  logic [CHW-1:0]  sel_ch;
  logic [NSEL-1:0] mask_ext;
  logic            sel_ok;
  logic            start_req;
  logic            finish;

  assign sel_ch    = ctrl_wdata[CHW:1];
  assign mask_ext  = NSEL'(ctrl_wdata[MASK_LSB+NCH-1:MASK_LSB]);
  assign sel_ok    = mask_ext[sel_ch];
  assign start_req = (state == S_IDLE) && ctrl_we && ctrl_wdata[0];
  assign finish    = (state == S_WAITLO) && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      ctrl_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ctrl_we) begin
            ctrl_q <= {ctrl_wdata[DW-1:1], 1'b0};
            if (ctrl_wdata[0] && sel_ok) begin
              if (ctrl_wdata[DLY_BIT]) begin
                state <= S_SETTLE;
                cnt   <= CW'(DELAY_CYC - 1);
              end else begin
                state <= S_LAUNCH;
              end
            end
          end
        end
        S_SETTLE: begin
          if (cnt == '0) state <= S_LAUNCH;
          else           cnt   <= cnt - 1'b1;
        end
        S_LAUNCH: state <= S_WAITHI;
        S_WAITHI: if (busy_i) state <= S_WAITLO;
        S_WAITLO: if (!busy_i) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state != S_IDLE);
  assign ctrl_o      = ctrl_q;
  assign cnv_start_o = (state == S_LAUNCH);
  assign res_we_o    = finish;
  assign res_o       = {~result_i[DW-1], result_i[DW-2:0]};
  assign done_evt_o  = finish || (start_req && !sel_ok);

  // R2: the strobe lasts one cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    cnv_start_o |=> !cnv_start_o);
  // R3: expiry of the settling count leads straight to the strobe
  a_r3_settle_launch: assert property (@(posedge clk) disable iff (rst)
    (state == S_SETTLE && cnt == '0) |=> cnv_start_o);
  // R8: control held while a conversion runs
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ctrl_we) |=> $stable(ctrl_q));
  // R9: a refused start does not enter the sequence
  a_r9_reject_idle: assert property (@(posedge clk) disable iff (rst)
    (start_req && !sel_ok) |=> !busy_o);
endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_ctl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy_i,
  input  logic [DW-1:0] ctrl_i,
  input  logic          done_evt_i,
  input  logic          res_we_i,
  input  logic [DW-1:0] res_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          done_q, ie_q, irq_q;
  logic          done_n, ie_n, clr_req;
  logic [DW-1:0] data_q, rd_n, stat_w, ien_w;
  logic          unused_ok;

  assign clr_req = we && (addr == REG_STAT) && wdata[DONE_BIT];
  assign done_n  = done_evt_i ? 1'b1 : (clr_req ? 1'b0 : done_q);
  assign ie_n    = (we && addr == REG_IEN) ? wdata[DONE_BIT] : ie_q;

  always_comb begin
    stat_w           = '0;
    stat_w[DONE_BIT] = done_q;
    stat_w[BUSY_BIT] = busy_i;
    ien_w            = '0;
    ien_w[DONE_BIT]  = ie_q;
    case (addr)
      REG_CTRL: rd_n = ctrl_i;
      REG_STAT: rd_n = stat_w;
      REG_IEN:  rd_n = ien_w;
      default:  rd_n = data_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      ie_q    <= 1'b0;
      irq_q   <= 1'b0;
      data_q  <= '0;
      rdata_o <= '0;
    end else begin
      done_q  <= done_n;
      ie_q    <= ie_n;
      irq_q   <= done_n && ie_n;
      rdata_o <= rd_n;
      if (res_we_i) data_q <= res_i;
    end
  end

  assign irq_o     = irq_q;
  assign unused_ok = ^{wdata[DW-1:DONE_BIT+1], wdata[DONE_BIT-1:0]};

  // R5: a completion always leaves done set
  a_r5_done_set: assert property (@(posedge clk) disable iff (rst)
    done_evt_i |=> done_q);
  // R6: write-one clears done when no completion coincides
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !done_evt_i) |=> !done_q);
  // R7: no interrupt while the enable is clear
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
    !ie_q |-> !irq_o);
  // R4: data register changes only on a result write
  a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
    !res_we_i |=> $stable(data_q));
endmodule

// File: rtl/adc_mux_ctrl.sv
module adc_mux_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CHW       = 4,
  parameter int NCH       = 10,
  parameter int DELAY_CYC = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq,
  output logic           cnv_start,
  output logic [CHW-1:0] cnv_chan,
  output logic [NCH-1:0] ch_enable,
  input  logic           cnv_busy,
  input  logic [DW-1:0]  cnv_result
);
  localparam int MASK_LSB = CHW + 1;

  logic          busy_w, done_evt_w, res_we_w;
  logic [DW-1:0] ctrl_w, res_w;
  logic          ctrl_we;

  assign ctrl_we = reg_we && (reg_addr == REG_CTRL);

  adc_seq #(.DW(DW), .CHW(CHW), .NCH(NCH), .DELAY_CYC(DELAY_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (reg_wdata),
    .busy_i     (cnv_busy),
    .result_i   (cnv_result),
    .busy_o     (busy_w),
    .ctrl_o     (ctrl_w),
    .cnv_start_o(cnv_start),
    .done_evt_o (done_evt_w),
    .res_we_o   (res_we_w),
    .res_o      (res_w)
  );

  adc_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .busy_i    (busy_w),
    .ctrl_i    (ctrl_w),
    .done_evt_i(done_evt_w),
    .res_we_i  (res_we_w),
    .res_i     (res_w),
    .rdata_o   (reg_rdata),
    .irq_o     (irq)
  );

  assign cnv_chan  = ctrl_w[CHW:1];
  assign ch_enable = ctrl_w[MASK_LSB+NCH-1:MASK_LSB];
endmodule

// File: tb/tb_adc_mux_ctrl.sv
module tb_adc_mux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DLY  = 8;
  localparam int CONV = 5;

  logic        clk = 0, rst = 1, reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, cnv_result;
  logic        irq, cnv_start, cnv_busy;
  logic [3:0]  cnv_chan;
  logic [9:0]  ch_enable;

  adc_mux_ctrl #(.DELAY_CYC(DLY)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .cnv_start(cnv_start), .cnv_chan(cnv_chan), .ch_enable(ch_enable),
    .cnv_busy(cnv_busy), .cnv_result(cnv_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, nstrobe = 0, conv_n = 0, ccnt = 0;
  bit cmp_on = 0, finished = 0;

  // converter model: busy for CONV cycles after a sampled strobe
  always @(posedge clk) begin
    if (rst) begin
      cnv_busy <= 0; cnv_result <= 16'h0000; ccnt <= 0;
    end else if (!cnv_busy && cnv_start) begin
      cnv_busy   <= 1; ccnt <= CONV;
      cnv_result <= 16'(conv_n * 16'h4D2B) ^ {cnv_chan, 12'h0A5};
      conv_n     <= conv_n + 1;
    end else if (cnv_busy) begin
      if (ccnt == 1) cnv_busy <= 0;
      ccnt <= ccnt - 1;
    end
    if (!rst && cnv_start) nstrobe <= nstrobe + 1;
  end

  // behavioural reference model
  logic [15:0] m_ctrl, m_data, m_ie, m_rd;
  logic        m_done, m_busy, m_irq;
  int          m_left;
  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_data = 0; m_ie = 0; m_rd = 0;
      m_done = 0; m_busy = 0; m_irq = 0; m_left = 0;
    end else begin
      bit b0, setd;
      int ch;
      case (reg_addr)
        2'd0: m_rd = m_ctrl;
        2'd1: m_rd = {13'b0, m_done, 1'b0, m_busy};
        2'd2: m_rd = m_ie;
        default: m_rd = m_data;
      endcase
      b0 = m_busy; setd = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; setd = 1; m_data = cnv_result ^ 16'h8000; end
      end
      if (reg_we && reg_addr == 0 && !b0) begin
        m_ctrl = reg_wdata & 16'hFFFE;
        if (reg_wdata[0]) begin
          ch = int'(reg_wdata[4:1]);
          if (ch < 10 && reg_wdata[5+ch]) begin
            m_busy = 1; m_left = (reg_wdata[15] ? DLY : 0) + CONV + 2;
          end else setd = 1;
        end
      end
      if (setd) m_done = 1;
      else if (reg_we && reg_addr == 1 && reg_wdata[2]) m_done = 0;
      if (reg_we && reg_addr == 2) m_ie = reg_wdata & 16'h0004;
      m_irq = m_done && m_ie[2];
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2/R3 strobe", 16'(cnv_start), 16'(m_busy && m_left == CONV + 2));
    chk("R2 channel", 16'(cnv_chan), 16'(m_ctrl[4:1]));
    chk("R2 enables", 16'(ch_enable), 16'(m_ctrl[14:5]));
    chk("R7 irq", 16'(irq), 16'(m_irq));
    chk("R10 rdata", reg_rdata, m_rd);
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); reg_we = 0; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  function automatic logic [15:0] cw(input int ch, input logic [9:0] mask,
                                     input bit dly, input bit go);
    return {dly, mask, 4'(ch), go};
  endfunction

  task automatic settle(); repeat (25) @(negedge clk); endtask

  logic [15:0] v, keep;
  int n, s0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; cmp_on = 1;
    // R1 reset state
    rd(2'd1, v); chk("R1 status", v, 16'h0000);
    rd(2'd3, v); chk("R1 data", v, 16'h0000);
    chk("R1 irq", 16'(irq), 16'h0);
    // R7 enable readback
    wr(2'd2, 16'hFFFF); rd(2'd2, v); chk("R7 ien bits", v, 16'h0004);
    // R2 start on channel 3 without delay
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = cw(3, 10'h008, 0, 1);
    @(negedge clk); reg_we = 0; n = 0;
    while (!cnv_start && n < 50) begin @(negedge clk); n++; end
    chk("R2 strobe latency", 16'(n), 16'd0);
    chk("R2 chan", 16'(cnv_chan), 16'd3);
    chk("R2 mask", 16'(ch_enable), 16'h0008);
    rd(2'd1, v); chk("R5 busy", v & 16'h0001, 16'h0001);
    settle();
    rd(2'd1, v); chk("R5 done", v, 16'h0004);
    chk("R7 irq on", 16'(irq), 16'h1);
    rd(2'd3, v); chk("R4 data", v, cnv_result ^ 16'h8000);
    rd(2'd0, v); chk("R10 ctrl bit0", v, cw(3, 10'h008, 0, 0));
    // R6 write-one-to-clear
    wr(2'd1, 16'hFFFB); rd(2'd1, v); chk("R6 zero write", v, 16'h0004);
    wr(2'd1, 16'h0004); rd(2'd1, v); chk("R6 clear", v, 16'h0000);
    chk("R7 irq off", 16'(irq), 16'h0);
    // R3 delayed start on reference channel 8
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = cw(8, 10'h100, 1, 1);
    @(negedge clk); reg_we = 0; n = 0;
    while (!cnv_start && n < 50) begin @(negedge clk); n++; end
    chk("R3 delay", 16'(n), 16'(DLY));
    settle();
    rd(2'd3, v); chk("R4 data ch8", v, cnv_result ^ 16'h8000);
    wr(2'd1, 16'h0004);
    // R8 control write during a conversion
    s0 = nstrobe;
    wr(2'd0, cw(1, 10'h3FF, 0, 1));
    wr(2'd0, cw(7, 10'h3FF, 1, 1));
    rd(2'd0, v); chk("R8 ctrl held", v, cw(1, 10'h3FF, 0, 0));
    settle();
    chk("R8 one strobe", 16'(nstrobe - s0), 16'd1);
    rd(2'd1, v); chk("R8 done once", v, 16'h0004);
    wr(2'd1, 16'h0004);
    // R9 rejected starts
    rd(2'd3, keep); s0 = nstrobe;
    wr(2'd0, cw(12, 10'h3FF, 0, 1));
    rd(2'd1, v); chk("R9 out of range done", v, 16'h0004);
    wr(2'd1, 16'h0004);
    wr(2'd0, cw(2, 10'h3FB, 0, 1));
    rd(2'd1, v); chk("R9 masked done", v, 16'h0004);
    settle();
    chk("R9 no strobe", 16'(nstrobe - s0), 16'd0);
    rd(2'd3, v); chk("R9 data kept", v, keep);
    // R10 data register is read-only
    wr(2'd3, 16'h1234); rd(2'd3, v); chk("R10 data ro", v, keep);
    // R7 gated off
    wr(2'd1, 16'h0004); wr(2'd2, 16'h0000);
    wr(2'd0, cw(0, 10'h001, 0, 1));
    settle();
    rd(2'd1, v); chk("R7 done set", v, 16'h0004);
    chk("R7 gated", 16'(irq), 16'h0);
    cmp_on = 0; finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule